// File: doc/BRIEF.md
# Low-Power Wakeup Detect Unit

This unit watches a group of external wakeup pins, one dedicated reset pin and a set of internal module wakeup requests while the chip sits in a low-power state. All of these inputs are asynchronous to the slow low-power clock that runs the unit. It raises either a wakeup alert or a reset request for the power controller.

Each external pin carries a two-bit edge selection. The pins pass through a synchronizer and then reach one of two paths. In the direct path, a configured edge sets the pin's status flag. In the filtered path, a single shared glitch filter watches the OR of the asserted levels of all enabled pins. The reset pin has a second, independent filter with its own enable. Internal module requests are synchronized but never filtered.

Status flags are sticky until software writes one to clear them. The wakeup alert is the OR of every set flag whose source is still enabled.

Top module: `lpwake_detect`

## Requirements
- R1: Every external, reset and module input passes a 2-stage synchronizer. With the wakeup filter off, a pin that rises before clock edge 1 with rising selection has its flag and wake_alert_o high after edge 3.
- R2: pin_edge_cfg_i[2i+1:2i] selects the mode of pin i: 2'b00 disabled, 2'b01 rising, 2'b10 falling, 2'b11 either edge. A disabled pin never sets its flag. The other codes set the flag on the matching synchronized transition.
- R3: With wk_filt_en_i high, the OR of the asserted levels of enabled pins must be sampled high on 3 consecutive edges before it is accepted. A level that lasts fewer than 3 samples sets nothing. Rising selection treats high as asserted and falling selection treats low as asserted. A pin that rises before edge 1 is accepted at edge 5.
- R4: A low sample of the filter input restarts the filter count from zero. A continuous assertion is accepted only once. At acceptance, only the pins that are asserted at that moment get their flags set.
- R5: A reset-pin event is a synchronized rising edge, or the output of the reset filter when rst_filt_en_i is high (same 3-sample rule, accepted at edge 5). The event sets pin_rst_flag_o and exit_flag_o and pulses reset_req_o for one cycle. It does not raise wake_alert_o.
- R6: Module request j sets mod_flag_o[j] without filtering, 3 edges after it rises, and only while mod_en_i[j] is high.
- R7: All status flags stay set until their clear input is high at a clock edge. A set and a clear on the same edge leave the flag set.
- R8: wake_alert_o is the OR of the pin flags whose pin is not disabled and the module flags whose enable is high. Every pin or module flag set also sets exit_flag_o.
- R9: cfg_err_o is high whenever wk_filt_en_i is high and any pin is set to 2'b11.
- R10: While rst_ni is low, all flags, reset_req_o and wake_alert_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Low-power clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wk_pin_i | input | NUM_PINS | External wakeup pins, asynchronous |
| rst_pin_i | input | 1 | Dedicated reset pin, high means asserted |
| mod_req_i | input | NUM_MODS | Internal module wakeup requests |
| pin_edge_cfg_i | input | 2*NUM_PINS | Per-pin edge selection |
| mod_en_i | input | NUM_MODS | Per-module wakeup enable |
| wk_filt_en_i | input | 1 | Shared wakeup filter enable |
| rst_filt_en_i | input | 1 | Reset-pin filter enable |
| pin_clr_i | input | NUM_PINS | Write-one-to-clear for pin flags |
| mod_clr_i | input | NUM_MODS | Write-one-to-clear for module flags |
| rst_clr_i | input | 1 | Clear for pin_rst_flag_o |
| exit_clr_i | input | 1 | Clear for exit_flag_o |
| wake_alert_o | output | 1 | Wakeup alert to the power controller |
| reset_req_o | output | 1 | One-cycle reset request |
| pin_flag_o | output | NUM_PINS | Sticky pin status flags |
| mod_flag_o | output | NUM_MODS | Sticky module status flags |
| pin_rst_flag_o | output | 1 | Sticky reset-pin status flag |
| exit_flag_o | output | 1 | Sticky low-power exit flag |
| cfg_err_o | output | 1 | Illegal filter plus either-edge configuration |

## Verification
The assertions check on every cycle that flags only clear through their clear inputs (R7) and that a flag rises only for a source that was enabled (R2, R6). They also check that the alert never appears without a flag (R8) and that a reset request always comes with both reset and exit flags (R5). The exact latencies of 3 and 5 edges, the discarding of short and broken pulses, the single acceptance per held level and the falling-level filtering depend on input history. Only the bench scenarios show these, using a reference model compared on every clock.

// File: rtl/lpwd_pkg.sv
package lpwd_pkg;
   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;
endpackage

// File: rtl/lpwd_sync.sv
module lpwd_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lpwd_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q <= '0;
      else         stage_q <= {stage_q[STAGES-2:0], d_i};
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/lpwd_glitch_filt.sv
module lpwd_glitch_filt #(
   parameter int CYCLES = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic lvl_i,
   output logic accept_o
);
   if (CYCLES < 1) begin : g_bad_cycles
      $error("lpwd_glitch_filt: CYCLES must be at least 1");
   end

   logic done_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              done_q <= 1'b0;
      else if (!en_i || !lvl_i) done_q <= 1'b0;
      else if (accept_o)        done_q <= 1'b1;
   end

   if (CYCLES == 1) begin : g_direct
      assign accept_o = en_i & lvl_i & ~done_q;
   end else begin : g_count
      localparam int CW = $clog2(CYCLES);
      localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                          cnt_q <= '0;
         else if (!en_i || !lvl_i || accept_o) cnt_q <= '0;
         else if (!done_q)                     cnt_q <= cnt_q + 1'b1;
      end

      assign accept_o = en_i & lvl_i & ~done_q & (cnt_q == LAST);
   end
endmodule

// File: rtl/lpwd_pin_qual.sv
module lpwd_pin_qual
   import lpwd_pkg::*;
(
   input  edge_sel_e sel_i,
   input  logic      lvl_i,
   input  logic      lvl_d_i,
   output logic      enabled_o,
   output logic      active_o,
   output logic      edge_o
);
   always_comb begin
      enabled_o = (sel_i != EDGE_OFF);
      active_o  = 1'b0;
      edge_o    = 1'b0;
      case (sel_i)
         EDGE_RISE: begin
            active_o = lvl_i;
            edge_o   = lvl_i & ~lvl_d_i;
         end
         EDGE_FALL: begin
            active_o = ~lvl_i;
            edge_o   = ~lvl_i & lvl_d_i;
         end
         EDGE_BOTH: begin
            active_o = lvl_i;
            edge_o   = lvl_i ^ lvl_d_i;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/lpwake_detect.sv
module lpwake_detect
   import lpwd_pkg::*;
#(
   parameter int NUM_PINS    = 4,
   parameter int NUM_MODS    = 3,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYCLES = 3
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [NUM_PINS-1:0]   wk_pin_i,
   input  logic                  rst_pin_i,
   input  logic [NUM_MODS-1:0]   mod_req_i,
   input  logic [2*NUM_PINS-1:0] pin_edge_cfg_i,
   input  logic [NUM_MODS-1:0]   mod_en_i,
   input  logic                  wk_filt_en_i,
   input  logic                  rst_filt_en_i,
   input  logic [NUM_PINS-1:0]   pin_clr_i,
   input  logic [NUM_MODS-1:0]   mod_clr_i,
   input  logic                  rst_clr_i,
   input  logic                  exit_clr_i,
   output logic                  wake_alert_o,
   output logic                  reset_req_o,
   output logic [NUM_PINS-1:0]   pin_flag_o,
   output logic [NUM_MODS-1:0]   mod_flag_o,
   output logic                  pin_rst_flag_o,
   output logic                  exit_flag_o,
   output logic                  cfg_err_o
);
   if (NUM_PINS < 1 || NUM_MODS < 1) begin : g_bad_counts
      $error("lpwake_detect: NUM_PINS and NUM_MODS must be at least 1");
   end

   localparam int SW     = NUM_PINS + 1;
   localparam int RST_IX = NUM_PINS;

   logic [SW-1:0]       syn, syn_d;
   logic [NUM_MODS-1:0] mod_syn, mod_set;
   logic [NUM_PINS-1:0] en_mask, act, edg, pin_set;
   logic                wk_acc, rst_acc, rst_evt;
   logic [NUM_PINS-1:0] pin_flag_q;
   logic [NUM_MODS-1:0] mod_flag_q;
   logic                prst_q, exit_q, rreq_q;

   lpwd_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_pin_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   ({rst_pin_i, wk_pin_i}),
      .q_o   (syn)
   );

   lpwd_sync #(.WIDTH(NUM_MODS), .STAGES(SYNC_STAGES)) u_mod_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (mod_req_i),
      .q_o   (mod_syn)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) syn_d <= '0;
      else         syn_d <= syn;
   end

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      lpwd_pin_qual u_qual (
         .sel_i    (edge_sel_e'(pin_edge_cfg_i[2*g +: 2])),
         .lvl_i    (syn[g]),
         .lvl_d_i  (syn_d[g]),
         .enabled_o(en_mask[g]),
         .active_o (act[g]),
         .edge_o   (edg[g])
      );
   end

   lpwd_glitch_filt #(.CYCLES(FILT_CYCLES)) u_wk_filt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (wk_filt_en_i),
      .lvl_i   (|act),
      .accept_o(wk_acc)
   );

   lpwd_glitch_filt #(.CYCLES(FILT_CYCLES)) u_rst_filt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (rst_filt_en_i),
      .lvl_i   (syn[RST_IX]),
      .accept_o(rst_acc)
   );

   always_comb begin
      if (wk_filt_en_i) pin_set = wk_acc ? act : '0;
      else              pin_set = edg;
      rst_evt = rst_filt_en_i ? rst_acc : (syn[RST_IX] & ~syn_d[RST_IX]);
      mod_set = mod_en_i & mod_syn;
   end

   always_comb begin
      cfg_err_o = 1'b0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (edge_sel_e'(pin_edge_cfg_i[2*i +: 2]) == EDGE_BOTH) cfg_err_o = wk_filt_en_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pin_flag_q <= '0;
         mod_flag_q <= '0;
         prst_q     <= 1'b0;
         exit_q     <= 1'b0;
         rreq_q     <= 1'b0;
      end else begin
         pin_flag_q <= (pin_flag_q & ~pin_clr_i) | pin_set;
         mod_flag_q <= (mod_flag_q & ~mod_clr_i) | mod_set;
         prst_q     <= (prst_q & ~rst_clr_i) | rst_evt;
         exit_q     <= (exit_q & ~exit_clr_i) | (|pin_set) | (|mod_set) | rst_evt;
         rreq_q     <= rst_evt;
      end
   end

   assign pin_flag_o     = pin_flag_q;
   assign mod_flag_o     = mod_flag_q;
   assign pin_rst_flag_o = prst_q;
   assign exit_flag_o    = exit_q;
   assign reset_req_o    = rreq_q;
   assign wake_alert_o   = (|(pin_flag_q & en_mask)) | (|(mod_flag_q & mod_en_i));
endmodule

// File: rtl/lpwake_detect_chk.sv
module lpwake_detect_chk #(
   parameter int NUM_PINS = 4,
   parameter int NUM_MODS = 3
) (
   input logic                  clk_i,
   input logic                  rst_ni,
   input logic [2*NUM_PINS-1:0] pin_edge_cfg_i,
   input logic [NUM_MODS-1:0]   mod_en_i,
   input logic [NUM_PINS-1:0]   pin_clr_i,
   input logic [NUM_MODS-1:0]   mod_clr_i,
   input logic                  wake_alert_o,
   input logic                  reset_req_o,
   input logic [NUM_PINS-1:0]   pin_flag_o,
   input logic [NUM_MODS-1:0]   mod_flag_o,
   input logic                  pin_rst_flag_o,
   input logic                  exit_flag_o
);
   logic [NUM_PINS-1:0] cfg_on;

   always_comb begin
      for (int i = 0; i < NUM_PINS; i++) cfg_on[i] = |pin_edge_cfg_i[2*i +: 2];
   end

   p_pin_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((~$past(pin_clr_i) & $past(pin_flag_o)) & ~pin_flag_o) == '0);

   p_mod_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((~$past(mod_clr_i) & $past(mod_flag_o)) & ~mod_flag_o) == '0);

   p_pin_needs_enable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((pin_flag_o & ~$past(pin_flag_o)) & ~$past(cfg_on)) == '0);

   p_mod_needs_enable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((mod_flag_o & ~$past(mod_flag_o)) & ~$past(mod_en_i)) == '0);

   p_alert_has_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_alert_o |-> ((|pin_flag_o) || (|mod_flag_o)));

   p_req_marks_flags_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reset_req_o |-> (pin_rst_flag_o && exit_flag_o));
endmodule

bind lpwake_detect lpwake_detect_chk #(
   .NUM_PINS(NUM_PINS),
   .NUM_MODS(NUM_MODS)
) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .pin_edge_cfg_i(pin_edge_cfg_i),
   .mod_en_i      (mod_en_i),
   .pin_clr_i     (pin_clr_i),
   .mod_clr_i     (mod_clr_i),
   .wake_alert_o  (wake_alert_o),
   .reset_req_o   (reset_req_o),
   .pin_flag_o    (pin_flag_o),
   .mod_flag_o    (mod_flag_o),
   .pin_rst_flag_o(pin_rst_flag_o),
   .exit_flag_o   (exit_flag_o)
);

// File: tb/lpwake_detect_tb_top.sv
module lpwake_detect_tb_top;
   localparam int NP = 4;
   localparam int NM = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NP-1:0] wk_pin;
   logic          rst_pin;
   logic [NM-1:0] mod_req, mod_en, mod_clr;
   logic [2*NP-1:0] cfg;
   logic          wk_filt, rst_filt, rst_clr, exit_clr;
   logic [NP-1:0] pin_clr;
   logic          wake_alert, reset_req, prst_flag, exit_flag, cfg_err;
   logic [NP-1:0] pin_flag;
   logic [NM-1:0] mod_flag;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   lpwake_detect dut_i (
      .clk_i(clk), .rst_ni(rst_n), .wk_pin_i(wk_pin), .rst_pin_i(rst_pin),
      .mod_req_i(mod_req), .pin_edge_cfg_i(cfg), .mod_en_i(mod_en),
      .wk_filt_en_i(wk_filt), .rst_filt_en_i(rst_filt), .pin_clr_i(pin_clr),
      .mod_clr_i(mod_clr), .rst_clr_i(rst_clr), .exit_clr_i(exit_clr),
      .wake_alert_o(wake_alert), .reset_req_o(reset_req), .pin_flag_o(pin_flag),
      .mod_flag_o(mod_flag), .pin_rst_flag_o(prst_flag), .exit_flag_o(exit_flag),
      .cfg_err_o(cfg_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Reference model: input history queues and run-length counters
   logic [NP:0]   pq[$];
   logic [NM-1:0] mq[$];
   int            wrun, rrun;
   logic [NP-1:0] m_pin, act_m, edg_m, set_m, enm;
   logic [NM-1:0] m_mod, mset;
   logic          m_prst, m_exit, m_rreq, orl, revt, e_err;
   logic [NP:0]   s, p;
   logic [1:0]    c;

   always @(posedge clk) begin
      if (!rst_n) begin
         pq = '{'0, '0, '0};
         mq = '{'0, '0, '0};
         wrun = 0; rrun = 0;
         m_pin = '0; m_mod = '0; m_prst = 0; m_exit = 0; m_rreq = 0;
      end else begin
         s = pq[1]; p = pq[0];
         act_m = '0; edg_m = '0;
         for (int i = 0; i < NP; i++) begin
            c = cfg[2*i +: 2];
            if (c == 2'b01) begin act_m[i] = s[i];  edg_m[i] = s[i] & ~p[i]; end
            if (c == 2'b10) begin act_m[i] = ~s[i]; edg_m[i] = ~s[i] & p[i]; end
            if (c == 2'b11) begin act_m[i] = s[i];  edg_m[i] = s[i] ^ p[i]; end
         end
         orl  = |act_m;
         wrun = (wk_filt && orl) ? wrun + 1 : 0;
         rrun = (rst_filt && s[NP]) ? rrun + 1 : 0;
         if (wk_filt) set_m = (wrun == 3) ? act_m : '0;
         else         set_m = edg_m;
         revt = rst_filt ? (rrun == 3) : (s[NP] & ~p[NP]);
         mset = mod_en & mq[1];
         m_pin  = (m_pin & ~pin_clr) | set_m;
         m_mod  = (m_mod & ~mod_clr) | mset;
         m_prst = (m_prst & ~rst_clr) | revt;
         m_exit = (m_exit & ~exit_clr) | (|set_m) | (|mset) | revt;
         m_rreq = revt;
         pq.push_back({rst_pin, wk_pin}); void'(pq.pop_front());
         mq.push_back(mod_req);           void'(mq.pop_front());
      end
      #5;
      if (rst_n) begin
         enm = '0; e_err = 0;
         for (int i = 0; i < NP; i++) begin
            enm[i] = |cfg[2*i +: 2];
            if (cfg[2*i +: 2] == 2'b11) e_err = wk_filt;
         end
         chk("R2/R3/R4 pin flags (model)", 32'(pin_flag), 32'(m_pin));
         chk("R6 module flags (model)", 32'(mod_flag), 32'(m_mod));
         chk("R5 reset flag (model)", 32'(prst_flag), 32'(m_prst));
         chk("R5 reset request (model)", 32'(reset_req), 32'(m_rreq));
         chk("R8 exit flag (model)", 32'(exit_flag), 32'(m_exit));
         chk("R8 wake alert (model)", 32'(wake_alert),
             32'((|(m_pin & enm)) | (|(m_mod & mod_en))));
         chk("R9 config error (model)", 32'(cfg_err), 32'(e_err));
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_all();
      pin_clr = '1; mod_clr = '1; rst_clr = 1; exit_clr = 1;
      step(1);
      pin_clr = '0; mod_clr = '0; rst_clr = 0; exit_clr = 0;
   endtask

   // Counts edges from the current negedge until the watched output goes high
   task automatic wait_count(input int sel, input int exp, input string tag);
      int   n = 0;
      logic seen = 0;
      while (!seen && n < 12) begin
         @(posedge clk); #5;
         n++;
         seen = (sel == 0) ? wake_alert : prst_flag;
      end
      chk(tag, 32'(n), 32'(exp));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 0; wk_pin = 4'b0010; rst_pin = 0; mod_req = '0; mod_en = '0;
      cfg = '0; wk_filt = 0; rst_filt = 0; pin_clr = '0; mod_clr = '0;
      rst_clr = 0; exit_clr = 0;
      step(2);
      chk("R10 reset flags", 32'({pin_flag, mod_flag, prst_flag, exit_flag}), 32'h0);
      chk("R10 reset alert/request", 32'({wake_alert, reset_req}), 32'h0);
      rst_n = 1;
      step(2);

      // R1: unfiltered rising edge, 3-edge latency
      cfg = 8'b00_00_00_01;
      step(1);
      wk_pin[0] = 1;
      wait_count(0, 3, "R1 unfiltered latency");
      chk("R1 pin0 flag", 32'(pin_flag), 32'h1);
      wk_pin[0] = 0;
      step(1);
      // R7: write-one-to-clear
      pin_clr = 4'b0001; step(1); pin_clr = '0;
      step(2);
      chk("R7 pin flag cleared", 32'(pin_flag), 32'h0);

      // R2: falling edge on pin1
      cfg = 8'b00_00_10_01;
      step(3);
      wk_pin[1] = 0;
      step(4);
      chk("R2 falling flag", 32'(pin_flag), 32'h2);
      clear_all();

      // R2: either edge on pin2
      cfg = 8'b00_11_10_01;
      wk_pin[2] = 1;
      step(4);
      chk("R2 either rising", 32'(pin_flag[2]), 32'h1);
      pin_clr = 4'b0100; step(1); pin_clr = '0;
      step(2);
      wk_pin[2] = 0;
      step(4);
      chk("R2 either falling", 32'(pin_flag[2]), 32'h1);

      // R2: disabled pin3 never flags
      wk_pin[3] = 1; step(4); wk_pin[3] = 0; step(4);
      chk("R2 disabled pin", 32'(pin_flag[3]), 32'h0);

      // R8: disabling a flagged pin removes it from the alert
      cfg = 8'b00_00_10_01;
      step(1);
      chk("R8 alert masked", 32'(wake_alert), 32'h0);
      chk("R8 flag kept", 32'(pin_flag[2]), 32'h1);
      clear_all();

      // Filter setup: pin0 rising, pin1 falling (held high = idle)
      wk_pin[1] = 1;
      step(4);
      clear_all();
      wk_filt = 1;
      step(2);
      // R3: 2-cycle pulse discarded
      wk_pin[0] = 1; step(2); wk_pin[0] = 0;
      step(8);
      chk("R3 short pulse", 32'({pin_flag, exit_flag}), 32'h0);
      // R4: broken pulse restarts count
      wk_pin[0] = 1; step(2); wk_pin[0] = 0; step(1); wk_pin[0] = 1; step(2); wk_pin[0] = 0;
      step(8);
      chk("R4 restart", 32'({pin_flag, exit_flag}), 32'h0);
      // R3: held pulse accepted at edge 5
      wk_pin[0] = 1;
      wait_count(0, 5, "R3 filtered latency");
      chk("R4 only asserted pin flagged", 32'(pin_flag), 32'h1);
      step(6);
      pin_clr = 4'b0001; exit_clr = 1; step(1); pin_clr = '0; exit_clr = 0;
      step(4);
      chk("R4 single acceptance", 32'(pin_flag), 32'h0);
      wk_pin[0] = 0;
      step(3);
      // R3: falling selection filters the low level
      wk_pin[1] = 0;
      step(6);
      chk("R3 falling filtered", 32'(pin_flag), 32'h2);
      wk_pin[1] = 1;
      step(3);
      clear_all();

      // R9: configuration error
      cfg = 8'b00_11_10_01;
      step(1);
      chk("R9 error raised", 32'(cfg_err), 32'h1);
      wk_filt = 0;
      step(1);
      chk("R9 error clear", 32'(cfg_err), 32'h0);
      cfg = 8'b00_00_10_01;
      step(2);

      // R5: unfiltered reset pin
      rst_pin = 1;
      wait_count(1, 3, "R5 unfiltered reset latency");
      chk("R5 exit flag", 32'(exit_flag), 32'h1);
      chk("R5 no wake alert", 32'(wake_alert), 32'h0);
      rst_pin = 0;
      step(3);
      clear_all();
      step(1);
      chk("R5 reset flag cleared", 32'(prst_flag), 32'h0);
      // R5: filtered reset pin
      rst_filt = 1;
      step(2);
      rst_pin = 1; step(2); rst_pin = 0;
      step(8);
      chk("R5 short reset pulse", 32'({prst_flag, exit_flag}), 32'h0);
      rst_pin = 1;
      wait_count(1, 5, "R5 filtered reset latency");
      rst_pin = 0;
      step(3);
      clear_all();
      rst_filt = 0;

      // R6: module requests
      mod_en = 3'b101;
      mod_req = 3'b111;
      step(4);
      chk("R6 module flags", 32'(mod_flag), 32'h5);
      chk("R8 module alert", 32'(wake_alert), 32'h1);
      mod_req = '0;
      step(3);
      clear_all();
      // R7: set wins over clear
      mod_en = 3'b001; mod_req = 3'b001;
      step(4);
      mod_clr = 3'b001; step(1); mod_clr = '0;
      chk("R7 set beats clear", 32'(mod_flag[0]), 32'h1);
      mod_req = '0;
      step(3);
      clear_all();
      step(1);
      chk("R7 module cleared", 32'(mod_flag), 32'h0);

      step(2);
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule